// File: doc/BRIEF.md
# Dual-Clock 512x9 FIFO with Two-Bit Fill Code

This block is a first-in first-out buffer of 512 nine-bit words. It sits between two clock domains. Each side has a free-running clock, a synchronous active-low reset and an enable. Data is captured on every write-clock rising edge while the write enable is high. A word is delivered on every read-clock rising edge while the read enable is high. The two clocks may be unrelated, or one clock may drive both sides. Reads and writes may fall on the same edge.

Fill status leaves the block as a single two-bit code that names one of four states. The read domain alone computes empty, almost empty and intermediate. The write domain alone computes almost full, and almost full takes precedence on the output. Pointers cross between the domains in Gray code through two-flop synchronizers. Each side therefore sees the far side's pointer late, and its flags err on the safe side.

The ninth bit can optionally serve as parity over the lower eight. A parameter selects the mode: parity off, generate on write, check on read, or both. The default is check. In check mode, a one-cycle error pulse accompanies any word whose nine bits hold an even number of ones.

Top module: `dcfifo_coded`

## Requirements
- R1: Words leave the read port in the order they were accepted, all 9 bits unchanged, and `rd_data` takes the new word on the read-clock edge that performs the read.
- R2: While `wr_en` is high and the buffer is not full, exactly one word is accepted on each write-clock rising edge, and 512 words can be held.
- R3: A write attempted while 512 words are held is ignored: the write pointer does not move and the word is lost.
- R4: A read attempted while the read-side code is 00 (empty) is ignored: `rd_data` and the read pointer keep their values.
- R5: `fill_code` encodes 00 = empty, 01 = 1 to 16 words (almost empty), 10 = 17 to 495 words (intermediate), 11 = 496 or more words (almost full, overriding the read-side code).
- R6: The empty, almost-empty and intermediate codes change only on read-clock edges. A read is reflected on the edge that performs it. With one clock driving both sides, a write first shows as non-empty on the third read-clock edge after the write edge.
- R7: Almost full changes only on write-clock edges. It is set on the write edge that brings the held count to 496. With one clock driving both sides, it is cleared on the third write-clock edge after the read that brings the count below 496.
- R8: After reset, `fill_code` is 00, `rd_data` is 0 and `parity_err` is 0.
- R9: In check mode, bit 8 is odd parity over bits 7:0. `parity_err` is high for exactly the read-clock cycle after a read whose word has an even count of ones over all 9 bits, and low otherwise.
- R10: A read and a write on the same edge both take effect, and the held count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous reset, active low |
| wr_en | input | 1 | Write enable, one word per edge while high |
| wr_data | input | 9 | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous reset, active low |
| rd_en | input | 1 | Read enable, one word per edge while high |
| rd_data | output | 9 | Registered output word |
| fill_code | output | 2 | Encoded fill state (see R5) |
| parity_err | output | 1 | One-cycle parity failure pulse on the read side |

## Verification
The almost-full boundary and the full state are hardest to reach from the ports. Getting there takes hundreds of back-to-back writes with no reads. The stimulus holds `wr_en` high for 600 cycles and checks the code at counts 495 and 496. It confirms that only 512 words survive. It then reads down through 496 and 495 to measure the three-edge lag before almost full clears. A separate sequence holds both enables high for 40 cycles around a partly filled buffer. This shows that same-edge traffic leaves the count unchanged and keeps the word order.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
// Package: shared fill-code type and parity mode selectors for the
// dual-clock FIFO. Assumes nothing beyond standard SystemVerilog.
package dcfifo_pkg;

    // Two-bit fill state shown at the block's status output
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'b00,
        FILL_LOW   = 2'b01,
        FILL_MID   = 2'b10,
        FILL_HIGH  = 2'b11
    } fill_code_e;

    // Parity mode bits: bit 0 generates on write, bit 1 checks on read
    localparam int PAR_OFF  = 0;
    localparam int PAR_GEN  = 1;
    localparam int PAR_CHK  = 2;
    localparam int PAR_BOTH = 3;

endpackage

// File: rtl/dcfifo_ram.sv
`timescale 1ns/1ps
// Module: dcfifo_ram
// Simple dual-port storage. Write port on wr_clk, registered read port on
// rd_clk. Assumes the controllers never write and read the same slot
// while the read is unsafe. The read register resets to zero.
module dcfifo_ram #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 9
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Capture an accepted word into its slot
    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Register the word being read out
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/dcfifo_sync.sv
`timescale 1ns/1ps
// Module: dcfifo_sync
// Carries a Gray-coded pointer into the destination domain through two
// flops, then converts it to binary. Assumes the source changes its Gray
// pointer by at most one bit per source edge.
module dcfifo_sync #(
    parameter int PTR_W = 10
) (
    input  logic             dst_clk,
    input  logic             dst_rst_n,
    input  logic [PTR_W-1:0] gray_in,
    output logic [PTR_W-1:0] bin_out
);
    logic [PTR_W-1:0] stage1;
    logic [PTR_W-1:0] stage2;

    // Two-flop synchronizer chain
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary: each bit folds in all higher Gray bits
    always_comb begin
        bin_out[PTR_W-1] = stage2[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage2[i];
        end
    end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
`timescale 1ns/1ps
// Module: dcfifo_wr_ctl
// Write-domain control: accepts words, keeps the binary and Gray write
// pointers, and owns the full and almost-full state. Assumes rd_bin_sync
// is the read pointer already carried into this domain, so its count is
// never below the true count.
module dcfifo_wr_ctl #(
    parameter int ADDR_W   = 9,
    parameter int AF_LEVEL = 496
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rd_bin_sync,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wr_bin,
    output logic [ADDR_W:0]   wr_gray,
    output logic              af_q
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic             full_q;
    logic [PTR_W-1:0] bin_nxt;
    logic [PTR_W-1:0] lvl_nxt;

    // Accept only when not full; compute the count after this edge
    always_comb begin
        wr_fire = wr_en && !full_q;
        bin_nxt = wr_bin + PTR_W'(wr_fire);
        lvl_nxt = bin_nxt - rd_bin_sync;
    end

    assign wr_addr = wr_bin[ADDR_W-1:0];

    // Advance pointers and register full / almost-full
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wr_bin  <= '0;
            wr_gray <= '0;
            full_q  <= 1'b0;
            af_q    <= 1'b0;
        end else begin
            wr_bin  <= bin_nxt;
            wr_gray <= (bin_nxt >> 1) ^ bin_nxt;
            full_q  <= (lvl_nxt == PTR_W'(DEPTH));
            af_q    <= (lvl_nxt >= PTR_W'(AF_LEVEL));
        end
    end
endmodule

// File: rtl/dcfifo_rd_ctl.sv
`timescale 1ns/1ps
// Module: dcfifo_rd_ctl
// Read-domain control: gates reads on the registered code, keeps the
// read pointers, and owns the empty / almost-empty / intermediate code.
// Assumes wr_bin_sync is the write pointer carried into this domain.
module dcfifo_rd_ctl
    import dcfifo_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int AE_LEVEL = 16
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wr_bin_sync,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_bin,
    output logic [ADDR_W:0]   rd_gray,
    output logic [1:0]        rd_code
);
    localparam int PTR_W = ADDR_W + 1;

    fill_code_e       code_q;
    fill_code_e       code_nxt;
    logic [PTR_W-1:0] bin_nxt;
    logic [PTR_W-1:0] lvl_nxt;

    // Read only when the shown code is not empty; count after this edge
    always_comb begin
        rd_fire = rd_en && (code_q != FILL_EMPTY);
        bin_nxt = rd_bin + PTR_W'(rd_fire);
        lvl_nxt = wr_bin_sync - bin_nxt;
        if (lvl_nxt == '0) begin
            code_nxt = FILL_EMPTY;
        end else if (lvl_nxt <= PTR_W'(AE_LEVEL)) begin
            code_nxt = FILL_LOW;
        end else begin
            code_nxt = FILL_MID;
        end
    end

    assign rd_addr = rd_bin[ADDR_W-1:0];
    assign rd_code = code_q;

    // Advance pointers and register the read-side code
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_bin  <= '0;
            rd_gray <= '0;
            code_q  <= FILL_EMPTY;
        end else begin
            rd_bin  <= bin_nxt;
            rd_gray <= (bin_nxt >> 1) ^ bin_nxt;
            code_q  <= code_nxt;
        end
    end
endmodule

// File: rtl/dcfifo_coded.sv
`timescale 1ns/1ps
// Module: dcfifo_coded
// Dual-clock FIFO, 2**ADDR_W words of DATA_W bits, with a two-bit fill
// code and optional parity on the top data bit. Assumes each reset is
// held for at least three cycles of its own clock and that both resets
// overlap. Almost full (write domain) overrides the read-domain code.
module dcfifo_coded
    import dcfifo_pkg::*;
#(
    parameter int DATA_W   = 9,
    parameter int ADDR_W   = 9,
    parameter int AE_LEVEL = 16,
    parameter int AF_LEVEL = 496,
    parameter int PAR_MODE = PAR_CHK
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        fill_code,
    output logic              parity_err
);
    localparam int  PTR_W  = ADDR_W + 1;
    localparam bit  DO_GEN = (PAR_MODE & PAR_GEN) != 0;
    localparam bit  DO_CHK = (PAR_MODE & PAR_CHK) != 0;

    logic              wr_fire;
    logic [ADDR_W-1:0] wr_addr;
    logic [PTR_W-1:0]  wr_bin;
    logic [PTR_W-1:0]  wr_gray;
    logic [PTR_W-1:0]  rd_bin_at_wr;
    logic              af_q;

    logic              rd_fire;
    logic [ADDR_W-1:0] rd_addr;
    logic [PTR_W-1:0]  rd_bin;
    logic [PTR_W-1:0]  rd_gray;
    logic [PTR_W-1:0]  wr_bin_at_rd;
    logic [1:0]        rd_code;
    logic              read_vld_q;

    logic [DATA_W-1:0] wr_word;

    // Optional parity generation on the stored top bit
    generate
        if (DO_GEN) begin : g_par_gen
            assign wr_word = {~(^wr_data[DATA_W-2:0]), wr_data[DATA_W-2:0]};
        end else begin : g_par_pass
            assign wr_word = wr_data;
        end
    endgenerate

    dcfifo_wr_ctl #(
        .ADDR_W   (ADDR_W),
        .AF_LEVEL (AF_LEVEL)
    ) u_wr_ctl (
        .wr_clk      (wr_clk),
        .wr_rst_n    (wr_rst_n),
        .wr_en       (wr_en),
        .rd_bin_sync (rd_bin_at_wr),
        .wr_fire     (wr_fire),
        .wr_addr     (wr_addr),
        .wr_bin      (wr_bin),
        .wr_gray     (wr_gray),
        .af_q        (af_q)
    );

    dcfifo_rd_ctl #(
        .ADDR_W   (ADDR_W),
        .AE_LEVEL (AE_LEVEL)
    ) u_rd_ctl (
        .rd_clk      (rd_clk),
        .rd_rst_n    (rd_rst_n),
        .rd_en       (rd_en),
        .wr_bin_sync (wr_bin_at_rd),
        .rd_fire     (rd_fire),
        .rd_addr     (rd_addr),
        .rd_bin      (rd_bin),
        .rd_gray     (rd_gray),
        .rd_code     (rd_code)
    );

    // Write pointer into the read domain
    dcfifo_sync #(.PTR_W(PTR_W)) u_sync_w2r (
        .dst_clk   (rd_clk),
        .dst_rst_n (rd_rst_n),
        .gray_in   (wr_gray),
        .bin_out   (wr_bin_at_rd)
    );

    // Read pointer into the write domain
    dcfifo_sync #(.PTR_W(PTR_W)) u_sync_r2w (
        .dst_clk   (wr_clk),
        .dst_rst_n (wr_rst_n),
        .gray_in   (rd_gray),
        .bin_out   (rd_bin_at_wr)
    );

    dcfifo_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .wr_clk   (wr_clk),
        .we       (wr_fire),
        .waddr    (wr_addr),
        .wdata    (wr_word),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .re       (rd_fire),
        .raddr    (rd_addr),
        .rdata    (rd_data)
    );

    // Mark the cycle in which rd_data holds a freshly read word
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            read_vld_q <= 1'b0;
        end else begin
            read_vld_q <= rd_fire;
        end
    end

    // Optional odd-parity check on the word just read
    generate
        if (DO_CHK) begin : g_par_chk
            assign parity_err = read_vld_q & ~(^rd_data);
        end else begin : g_par_nochk
            assign parity_err = 1'b0;
        end
    endgenerate

    // Almost full from the write side overrides the read-side code
    assign fill_code = af_q ? FILL_HIGH : rd_code;
endmodule

// File: rtl/dcfifo_coded_chk.sv
`timescale 1ns/1ps
// Module: dcfifo_coded_chk
// Assertion checker bound into dcfifo_coded. Observes pointers, the
// read-side code and the outputs; drives nothing.
module dcfifo_coded_chk #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 9
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_en,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic [DATA_W-1:0] rd_data,
    input logic              parity_err,
    input logic [ADDR_W:0]   wr_bin,
    input logic [ADDR_W:0]   rd_bin_at_wr,
    input logic              wr_fire,
    input logic              af_q,
    input logic [ADDR_W:0]   rd_bin,
    input logic              rd_fire,
    input logic [1:0]        rd_code
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PTR_W-1:0] wr_side_lvl;
    assign wr_side_lvl = wr_bin - rd_bin_at_wr;

    // R3: the write-side count never exceeds the capacity
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_side_lvl <= PTR_W'(DEPTH));

    // R3: an attempted write while full leaves the write pointer alone
    a_r3_full_hold: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_en && wr_side_lvl == PTR_W'(DEPTH)) |=> $stable(wr_bin));

    // R4: while the read side shows empty, nothing is read
    a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_code == 2'b00) |=> ($stable(rd_bin) && $stable(rd_data)));

    // R5: the read domain never produces the almost-full code
    a_r5_rd_code_range: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_code != 2'b11);

    // R7: almost full only rises on an edge that accepted a word
    a_r7_af_rise: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(af_q) |-> $past(wr_fire));

    // R9: a parity error pulse only follows a read
    a_r9_perr_after_read: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        parity_err |-> $past(rd_fire));
endmodule

bind dcfifo_coded dcfifo_coded_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .wr_clk       (wr_clk),
    .wr_rst_n     (wr_rst_n),
    .wr_en        (wr_en),
    .rd_clk       (rd_clk),
    .rd_rst_n     (rd_rst_n),
    .rd_data      (rd_data),
    .parity_err   (parity_err),
    .wr_bin       (wr_bin),
    .rd_bin_at_wr (rd_bin_at_wr),
    .wr_fire      (wr_fire),
    .af_q         (af_q),
    .rd_bin       (rd_bin),
    .rd_fire      (rd_fire),
    .rd_code      (rd_code)
);

// File: tb/test_dcfifo_coded.sv
`timescale 1ns/1ps
// Directed bench for dcfifo_coded. One 100 MHz clock drives both sides.
// Inputs change and outputs are sampled on falling edges.
module test_dcfifo_coded;

    logic       clk;
    logic       rst_n;
    logic       wr_en;
    logic [8:0] wr_data;
    logic       rd_en;
    logic [8:0] rd_data;
    logic [1:0] fill_code;
    logic       parity_err;

    int checks = 0;
    int errs   = 0;

    dcfifo_coded i_dcfifo_coded (
        .wr_clk     (clk),
        .wr_rst_n   (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_clk     (clk),
        .rd_rst_n   (rst_n),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .fill_code  (fill_code),
        .parity_err (parity_err)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Word with correct odd parity in bit 8
    function automatic logic [8:0] good(input int v);
        logic [7:0] b;
        b = v[7:0];
        return {~(^b), b};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_one(input logic [8:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
    endtask

    task automatic rd_one(input string req, input logic [8:0] exp);
        rd_en = 1'b1;
        @(negedge clk);
        chk(req, "rd_data", int'(rd_data), int'(exp));
    endtask

    task automatic idle(input int n);
        wr_en = 1'b0;
        rd_en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic int code_for(input int lvl);
        if (lvl == 0)   return 0;
        if (lvl <= 16)  return 1;
        if (lvl >= 496) return 3;
        return 2;
    endfunction

    // R8: reset values
    task automatic t_reset();
        chk("R8", "fill_code", int'(fill_code), 0);
        chk("R8", "rd_data", int'(rd_data), 0);
        chk("R8", "parity_err", int'(parity_err), 0);
    endtask

    // R4 / R6: reads on empty are ignored; write visibility lag
    task automatic t_empty_and_lag();
        rd_en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R4", "rd_data on empty", int'(rd_data), 0);
            chk("R4", "fill_code on empty", int'(fill_code), 0);
        end
        rd_en = 1'b0;
        wr_one(good(8'hA5));
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R6", "code two edges after write", int'(fill_code), 0);
        @(negedge clk);
        chk("R6", "code three edges after write", int'(fill_code), 1);
        rd_one("R1", good(8'hA5));
        rd_en = 1'b0;
        chk("R6", "code right after last read", int'(fill_code), 0);
        chk("R9", "parity_err on good word", int'(parity_err), 0);
        rd_en = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk("R4", "rd_data held after empty read", int'(rd_data), int'(good(8'hA5)));
        end
        rd_en = 1'b0;
    endtask

    // R1 / R2 / R5: burst of 20, then drain across the 17/16 boundary
    task automatic t_order_levels();
        for (int i = 0; i < 20; i++) wr_one(good(i + 16));
        idle(4);
        chk("R5", "code at 20 words", int'(fill_code), 2);
        for (int k = 1; k <= 20; k++) begin
            rd_one("R1", good(k + 15));
            chk("R5", "code while draining", int'(fill_code), code_for(20 - k));
        end
        rd_en = 1'b0;
    endtask

    // R9: bad parity word followed by good word
    task automatic t_parity();
        logic [8:0] bad;
        bad = {^8'h3C, 8'h3C};
        wr_one(bad);
        wr_one(good(8'h81));
        idle(4);
        rd_one("R9", bad);
        chk("R9", "parity_err after bad word", int'(parity_err), 1);
        rd_one("R9", good(8'h81));
        chk("R9", "parity_err pulse ends", int'(parity_err), 0);
        rd_en = 1'b0;
        @(negedge clk);
        chk("R9", "parity_err idle", int'(parity_err), 0);
    endtask

    // R10: simultaneous read and write keep order and count
    task automatic t_simul();
        for (int i = 0; i < 20; i++) wr_one(good(i + 64));
        idle(4);
        for (int j = 0; j < 40; j++) begin
            wr_en   = 1'b1;
            wr_data = good(j + 84);
            rd_one("R10", good(j + 64));
        end
        idle(4);
        chk("R10", "code after mixed traffic", int'(fill_code), 2);
        for (int k = 0; k < 20; k++) rd_one("R10", good(k + 104));
        rd_en = 1'b0;
        chk("R10", "code after drain", int'(fill_code), 0);
    endtask

    // R2 / R3 / R5 / R7: fill past capacity, then drain across 496/495
    task automatic t_full();
        for (int i = 0; i < 600; i++) begin
            wr_one(good(i));
            if (i + 1 == 495) chk("R5", "code at 495 words", int'(fill_code), 2);
            if (i + 1 == 496) chk("R7", "code at 496 words", int'(fill_code), 3);
        end
        idle(4);
        chk("R3", "code while full", int'(fill_code), 3);
        for (int k = 0; k < 16; k++) rd_one("R2", good(k));
        idle(4);
        chk("R7", "code at 496 after reads", int'(fill_code), 3);
        rd_one("R2", good(16));
        rd_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7", "almost full two edges after read", int'(fill_code), 3);
        @(negedge clk);
        chk("R7", "almost full cleared third edge", int'(fill_code), 2);
        for (int k = 17; k < 512; k++) rd_one("R3", good(k));
        rd_en = 1'b0;
        chk("R3", "empty after 512 reads", int'(fill_code), 0);
        rd_en = 1'b1;
        @(negedge clk);
        chk("R3", "no word beyond 512", int'(rd_data), int'(good(511)));
        rd_en = 1'b0;
    endtask

    initial begin
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        rd_en   = 1'b0;
        wr_data = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_empty_and_lag();
        t_order_levels();
        t_parity();
        t_simul();
        t_full();
        idle(2);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule